// File: doc/BRIEF.md
# Triggered Stream Capture Controller

This block takes a free-running stream of 8-bit converter samples and stores a window of it in on-chip dual-port memory. The stream side has a valid signal and a ready signal. Ready is always high, because the source cannot be paused. A host on the bus clock arms a capture by writing a control register. In the converter clock domain, an address generator then writes each valid sample to the next memory location. The capture stops when the buffer is full. Any samples that arrive after that, or while no capture is armed, are discarded.

The host polls a status register for busy and done, and reads a register that holds the number of samples stored. It then reads the samples back through a second port on the memory, in its own clock domain. Both the start and abort commands reach the converter domain as toggles passed through two-flop synchronizers. The end of a capture returns to the bus side the same way.

Register map (bus side, word offsets):
- Offset 0 is control, write-only, and reads as 0. Bit 0 starts a capture. Bit 1 aborts one.
- Offset 1 is status. Bit 0 is busy and bit 1 is done.
- Offset 2 holds the sample count.
- Offset 3 reads as 0.

Top module: `stream_snap_top`

## Requirements
- R1: `st_ready` is 1 in every cycle, including during reset, while idle and after the buffer has filled.
- R2: After a start, the n-th valid sample (n counting from 0) is written to memory address n. Cycles with `st_valid` low neither write nor advance the address.
- R3: When no capture is running, incoming samples are not written, and the memory contents and the count stay unchanged.
- R4: A capture ends by itself after DEPTH samples have been written. Samples after that are dropped, and the count then reads DEPTH.
- R5: Status bit 0 (busy) reads 1 from the cycle after an accepted start until the end of the capture has crossed back to the bus domain. Status bit 1 (done) reads 1 when at least one capture has been started since reset and busy is 0.
- R6: A start written while busy is 1 is ignored. The running capture keeps its address and count and is not restarted.
- R7: An abort written while busy ends the capture, and the count holds the number of samples written before the abort. An abort written while idle has no effect on status or count.
- R8: After reset, status and count read 0. An accepted start clears the count to 0, and the next capture begins at address 0.
- R9: A register read or a memory read returns its data on `csr_readdata` or `mem_readdata` one bus clock after the cycle in which the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| adc_clk | input | 1 | Sample stream clock |
| adc_rst | input | 1 | Synchronous active-high reset, stream domain |
| st_valid | input | 1 | Sample present this cycle |
| st_data | input | 8 | Sample value |
| st_ready | output | 1 | Always 1 (no backpressure) |
| csr_addr | input | 2 | Register word offset |
| csr_write | input | 1 | Register write strobe |
| csr_writedata | input | 2 | Control bits: bit 0 start, bit 1 abort |
| csr_read | input | 1 | Register read strobe |
| csr_readdata | output | 32 | Register read data, one cycle after the read |
| mem_addr | input | log2(DEPTH) | Sample buffer read address |
| mem_read | input | 1 | Sample buffer read strobe |
| mem_readdata | output | 8 | Stored sample, one cycle after the read |

## Verification
The assertions assume that the bus side forwards a start toggle only while idle and an abort toggle only while busy. They also assume that the count crossing into the bus domain is stable by the time the end toggle arrives, which holds because the count stops changing when that toggle is launched. The stimulus keeps to these conditions by waiting several stream clocks after each start before it sends samples, and several bus clocks after each capture ends before it reads status or count. Inside captures the valid pattern has gaps filled with junk data, and more samples are sent than the buffer holds.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam int CTRL_START = 0;
  localparam int CTRL_ABORT = 1;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_DONE  = 1;
endpackage

// File: rtl/snap_sync.sv
module snap_sync (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/snap_ram.sv
module snap_ram #(
  parameter int DEPTH = 4096,
  parameter int SW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);
  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/snap_writer.sv
module snap_writer #(
  parameter int DEPTH = 4096,
  parameter int SW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_tgl_raw,
  input  logic          abort_tgl_raw,
  input  logic          st_valid,
  input  logic [SW-1:0] st_data,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [SW-1:0] wdata,
  output logic          end_tgl,
  output logic [CW-1:0] count
);
  logic start_s, abort_s, start_d, abort_d;
  logic start_edge, abort_edge, busy, last;

  snap_sync u_sync_start (.clk(clk), .rst(rst), .d(start_tgl_raw), .q(start_s));
  snap_sync u_sync_abort (.clk(clk), .rst(rst), .d(abort_tgl_raw), .q(abort_s));

  assign start_edge = start_s ^ start_d;
  assign abort_edge = abort_s ^ abort_d;
  assign last       = (count == CW'(DEPTH - 1));
  assign we         = busy && st_valid && !abort_edge;
  assign waddr      = count[AW-1:0];
  assign wdata      = st_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_d <= 1'b0;
      abort_d <= 1'b0;
      busy    <= 1'b0;
      end_tgl <= 1'b0;
      count   <= '0;
    end else begin
      start_d <= start_s;
      abort_d <= abort_s;
      if (!busy) begin
        if (start_edge) begin
          busy  <= 1'b1;
          count <= '0;
        end
      end else if (abort_edge) begin
        busy    <= 1'b0;
        end_tgl <= ~end_tgl;
      end else if (st_valid) begin
        count <= count + 1'b1;
        if (last) begin
          busy    <= 1'b0;
          end_tgl <= ~end_tgl;
        end
      end
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (count < CW'(DEPTH))); // R4
  AST_NEVER_PAST_FULL: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R4
  AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    we |=> (count == $past(count) + 1'b1)); // R2
  AST_COUNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_edge) |=> $stable(count)); // R3
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    csr_addr,
  input  logic          csr_write,
  input  logic [1:0]    csr_writedata,
  input  logic          csr_read,
  output logic [31:0]   csr_readdata,
  output logic          start_tgl,
  output logic          abort_tgl,
  input  logic          end_tgl_raw,
  input  logic [CW-1:0] cnt_raw
);
  import snap_pkg::*;

  logic ack_s, ack_d, busy, done, started, ack_edge, wr_ctrl, take_start;
  logic [CW-1:0] cnt_q;

  snap_sync u_sync_end (.clk(clk), .rst(rst), .d(end_tgl_raw), .q(ack_s));

  assign ack_edge   = ack_s ^ ack_d;
  assign busy       = start_tgl ^ ack_d;
  assign done       = started && !busy;
  assign wr_ctrl    = csr_write && (csr_addr == REG_CTRL);
  assign take_start = wr_ctrl && csr_writedata[CTRL_START] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_tgl    <= 1'b0;
      abort_tgl    <= 1'b0;
      ack_d        <= 1'b0;
      started      <= 1'b0;
      cnt_q        <= '0;
      csr_readdata <= '0;
    end else begin
      ack_d <= ack_s;
      if (ack_edge) cnt_q <= cnt_raw;
      if (take_start) begin
        start_tgl <= ~start_tgl;
        started   <= 1'b1;
        cnt_q     <= '0;
      end else if (wr_ctrl && csr_writedata[CTRL_ABORT] && busy) begin
        abort_tgl <= ~abort_tgl;
      end
      if (csr_read) begin
        case (csr_addr)
          REG_STAT: begin
            csr_readdata            <= '0;
            csr_readdata[STAT_BUSY] <= busy;
            csr_readdata[STAT_DONE] <= done;
          end
          REG_CNT: csr_readdata <= 32'(cnt_q);
          default: csr_readdata <= '0;
        endcase
      end
    end
  end

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && csr_writedata[CTRL_START] && busy) |=> $stable(start_tgl)); // R6
  AST_CNT_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(wr_ctrl && csr_writedata[CTRL_START])) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/stream_snap_top.sv
module stream_snap_top #(
  parameter int DEPTH = 4096,
  parameter int SW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          bus_clk,
  input  logic          bus_rst,
  input  logic          adc_clk,
  input  logic          adc_rst,
  input  logic          st_valid,
  input  logic [SW-1:0] st_data,
  output logic          st_ready,
  input  logic [1:0]    csr_addr,
  input  logic          csr_write,
  input  logic [1:0]    csr_writedata,
  input  logic          csr_read,
  output logic [31:0]   csr_readdata,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_read,
  output logic [SW-1:0] mem_readdata
);
  logic          start_tgl, abort_tgl, end_tgl, we;
  logic [AW-1:0] waddr;
  logic [SW-1:0] wdata;
  logic [CW-1:0] count;

  assign st_ready = 1'b1;

  snap_ctrl #(.CW(CW)) u_ctrl (
    .clk(bus_clk), .rst(bus_rst),
    .csr_addr(csr_addr), .csr_write(csr_write), .csr_writedata(csr_writedata),
    .csr_read(csr_read), .csr_readdata(csr_readdata),
    .start_tgl(start_tgl), .abort_tgl(abort_tgl),
    .end_tgl_raw(end_tgl), .cnt_raw(count)
  );

  snap_writer #(.DEPTH(DEPTH), .SW(SW)) u_writer (
    .clk(adc_clk), .rst(adc_rst),
    .start_tgl_raw(start_tgl), .abort_tgl_raw(abort_tgl),
    .st_valid(st_valid), .st_data(st_data),
    .we(we), .waddr(waddr), .wdata(wdata),
    .end_tgl(end_tgl), .count(count)
  );

  snap_ram #(.DEPTH(DEPTH), .SW(SW)) u_ram (
    .wclk(adc_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(bus_clk), .re(mem_read), .raddr(mem_addr), .rdata(mem_readdata)
  );
endmodule

// File: tb/sim_stream_snap_top.sv
module sim_stream_snap_top;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic bus_clk = 1'b0, adc_clk = 1'b0;
  logic bus_rst = 1'b1, adc_rst = 1'b1;
  logic st_valid = 1'b0;
  logic [7:0] st_data = '0;
  logic st_ready;
  logic [1:0] csr_addr = '0;
  logic csr_write = 1'b0;
  logic [1:0] csr_writedata = '0;
  logic csr_read = 1'b0;
  logic [31:0] csr_readdata;
  logic [AW-1:0] mem_addr = '0;
  logic mem_read = 1'b0;
  logic [7:0] mem_readdata;

  int n_chk = 0, n_bad = 0;

  always #10 bus_clk = ~bus_clk;   // 50 MHz
  always #6  adc_clk = ~adc_clk;

  stream_snap_top #(.DEPTH(DEPTH)) u0 (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .adc_clk(adc_clk), .adc_rst(adc_rst),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready),
    .csr_addr(csr_addr), .csr_write(csr_write), .csr_writedata(csr_writedata),
    .csr_read(csr_read), .csr_readdata(csr_readdata),
    .mem_addr(mem_addr), .mem_read(mem_read), .mem_readdata(mem_readdata)
  );

  // vector fields: samples sent, base value, step, invalid gap, expected count
  localparam logic [39:0] VEC [3] = '{
    {8'd16, 8'h10, 8'd1, 8'd0, 8'd16},
    {8'd24, 8'hA0, 8'd3, 8'd1, 8'd16},
    {8'd20, 8'hF0, 8'd7, 8'd2, 8'd16}
  };

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic csr_wr(logic [1:0] a, logic [1:0] d);
    @(negedge bus_clk);
    csr_addr = a; csr_writedata = d; csr_write = 1'b1;
    @(negedge bus_clk);
    csr_write = 1'b0; csr_writedata = '0;
  endtask

  task automatic csr_rd(logic [1:0] a, output int v);
    @(negedge bus_clk);
    csr_addr = a; csr_read = 1'b1;
    @(negedge bus_clk);
    csr_read = 1'b0;
    v = int'(csr_readdata);
  endtask

  task automatic mem_rd(int a, output int v);
    @(negedge bus_clk);
    mem_addr = AW'(a); mem_read = 1'b1;
    @(negedge bus_clk);
    mem_read = 1'b0;
    v = int'(mem_readdata);
  endtask

  task automatic send(int n, logic [7:0] base, logic [7:0] step, int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge adc_clk);
        st_valid = 1'b0; st_data = 8'h5A;
      end
      @(negedge adc_clk);
      st_valid = 1'b1; st_data = base + step * 8'(i);
    end
    @(negedge adc_clk);
    st_valid = 1'b0;
  endtask

  task automatic bus_wait(int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic adc_wait(int n);
    repeat (n) @(negedge adc_clk);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    check("R1 ready in reset", int'(st_ready), 1);
    repeat (4) @(negedge bus_clk);
    bus_rst = 1'b0;
    @(negedge adc_clk); adc_rst = 1'b0;
    bus_wait(2);

    // reset state and unused offsets
    csr_rd(2'd1, v); check("R8 status after reset", v, 0);
    csr_rd(2'd2, v); check("R8 count after reset", v, 0);
    csr_rd(2'd0, v); check("R9 control reads zero", v, 0);
    csr_rd(2'd3, v); check("R9 offset 3 reads zero", v, 0);

    // table of captures
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ns, bs, sp, gp, ec;
      {ns, bs, sp, gp, ec} = VEC[k];
      csr_wr(2'd0, 2'b01);
      csr_rd(2'd1, v); check("R5 busy after start", v, 1);
      csr_rd(2'd2, v); check("R8 count cleared by start", v, 0);
      adc_wait(8);
      send(int'(ns), bs, sp, int'(gp));
      check("R1 ready after stream", int'(st_ready), 1);
      bus_wait(12);
      csr_rd(2'd1, v); check("R5 done after capture", v, 2);
      csr_rd(2'd2, v); check("R4 count at full", v, int'(ec));
      for (int i = 0; i < DEPTH; i++) begin
        mem_rd(i, v); check("R2 stored sample", v, int'(8'(bs + sp * 8'(i))));
      end
    end

    // R3: samples while idle are not stored
    send(6, 8'h33, 8'd0, 0);
    bus_wait(4);
    mem_rd(0, v); check("R3 idle sample dropped at 0", v, 8'hF0);
    mem_rd(5, v); check("R3 idle sample dropped at 5", v, int'(8'(8'hF0 + 8'd35)));
    csr_rd(2'd2, v); check("R3 count unchanged while idle", v, 16);

    // R6 and R7: restart ignored, abort mid-capture
    csr_wr(2'd0, 2'b01);
    adc_wait(8);
    send(5, 8'h40, 8'd1, 1);
    csr_wr(2'd0, 2'b01);
    adc_wait(8);
    send(5, 8'h45, 8'd1, 0);
    bus_wait(4);
    csr_rd(2'd1, v); check("R6 still busy after second start", v, 1);
    csr_wr(2'd0, 2'b10);
    bus_wait(12);
    csr_rd(2'd1, v); check("R7 done after abort", v, 2);
    csr_rd(2'd2, v); check("R6 count continued through restart", v, 10);
    mem_rd(0, v); check("R6 address not restarted", v, 8'h40);
    mem_rd(9, v); check("R7 last sample before abort", v, 8'h49);
    send(3, 8'h77, 8'd1, 0);
    bus_wait(4);
    mem_rd(10, v); check("R7 no write after abort", v, int'(8'(8'hF0 + 8'd70)));

    // abort while idle
    csr_wr(2'd0, 2'b10);
    bus_wait(12);
    csr_rd(2'd1, v); check("R7 idle abort leaves status", v, 2);
    csr_rd(2'd2, v); check("R7 idle abort leaves count", v, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule